// File: doc/BRIEF.md
# Handshaked Serial Peripheral Master

This block is a single-slave SPI master with a fifth wire. Besides the serial clock, the two data lines and an active-low select, it has an active-low ready input, `en_n`, that the slave drives. The master holds back the first clock edge of every word until the slave pulls that line low. This lets a slow slave stretch the gap between words without any software polling.

The host hands over one 8-bit word at a time with a valid/ready pair. With each word it also passes a flag that asks the master to keep the select asserted if another word follows straight away. The received word comes back on `rx_data` with a one-cycle `rx_valid` strobe. Clock polarity, clock phase and the divider are inputs. Two 5-bit fields add system-clock periods to the select-to-clock gap and to the clock-to-deselect gap. The mode and the divider are captured when a word is accepted from idle.

The clock divider counts `half_div` system clocks per SPI half period. `en_n` passes through a two-stage synchronizer before it is used.

Top module: `spim_ready_hs`

## Requirements
- R1: After reset `cs_n` is 1, `tx_ready` is 1 and `rx_valid` is 0. While idle, `sclk` settles to the level of `cpol` one cycle after `cpol` changes.
- R2: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 1 in idle. Once a word is accepted, `tx_ready` stays 0 while `cs_n` is low, except in the single cycle that ends the post-transfer delay of a word sent with `tx_keep_cs`=1.
- R3: Each word uses exactly 16 `sclk` edges and is shifted MSB first on both `mosi` and `miso`. The first edge of a word moves `sclk` away from its idle level. With `cpha`=0, `mosi` holds bit 7 from the moment `cs_n` falls; both sides sample on the leading (odd-numbered) edges and change on the trailing edges. With `cpha`=1, data changes on the leading edges and is sampled on the trailing edges.
- R4: With `en_n` already low, the first `sclk` edge comes exactly `2 + setup_ext + half_div` system-clock periods after `cs_n` falls.
- R5: `cs_n` rises exactly `1 + hold_ext` system-clock periods after the 16th `sclk` edge of a word that does not continue.
- R6: No `sclk` edge occurs while the synchronized `en_n` is high. This applies before the first word and after the final edge of a word that is followed by another one. Once `en_n` falls, the first edge comes `2 + half_div` periods after the first rising clock edge that samples it low.
- R7: At the end of each word's post-transfer delay, `rx_data` carries the bits sampled from `miso` and `rx_valid` is 1 for exactly one cycle. For a released word, this is the same cycle in which `cs_n` goes high.
- R8: If the finished word had `tx_keep_cs`=1 and `tx_valid` is 1 when its post-transfer delay ends, the next word is accepted in that cycle and `cs_n` stays low between the two words.
- R9: If the finished word had `tx_keep_cs`=1 but no word is waiting, `cs_n` is released exactly as in R5.
- R10: Every `sclk` half period within a word lasts exactly `half_div` system-clock periods (`half_div` of 1 or more).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| half_div | input | DIV_W | System clocks per `sclk` half period, at least 1 |
| setup_ext | input | DLY_W | Extra periods between select and first edge |
| hold_ext | input | DLY_W | Extra periods between last edge and deselect |
| tx_data | input | DATA_W | Word to send |
| tx_valid | input | 1 | Host offers `tx_data` |
| tx_keep_cs | input | 1 | Keep select asserted if another word follows |
| tx_ready | output | 1 | Master can take a word this cycle |
| rx_data | output | DATA_W | Word received from the slave |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Slave select, active low |
| en_n | input | 1 | Slave ready, active low, asynchronous |

## Verification
Any slip in the delay counters shows up at once as a wrong gap, measured in nanoseconds, between a `cs_n` transition and the nearest `sclk` edge. The divider is checked against every half period of every word. A wrong edge counter or a wrong launch/sample choice corrupts the byte the slave model captures or the byte returned on `rx_data`, and that shows within the same word. A sequencer that ignores the ready line gives `sclk` edges while `en_n` is held high. A broken hold path gives an extra `cs_n` rise between kept words, which the bench sees within one post-transfer delay.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Sequencer phases of one transfer
    typedef enum logic [2:0] {
        ST_IDLE,     // select released, waiting for a word
        ST_SETUP,    // select asserted, counting the lead-in gap
        ST_WAIT_EN,  // waiting for the slave ready line
        ST_SHIFT,    // clock running, 16 edges
        ST_HOLD      // counting the tail gap after the last edge
    } spim_state_e;

    // Signals handed from sequencer to datapath each cycle
    typedef struct packed {
        logic load;    // capture a new word into the shifter
        logic run;     // divider active
        logic idle;    // clock follows live polarity
        logic finish;  // post-transfer delay ends this cycle
    } spim_ctl_t;

    // Edges with an even index (0-based) leave the idle level.
    function automatic logic edge_is_leading(input logic idx_lsb);
        return !idx_lsb;
    endfunction

    // phase 0 samples on leading edges, phase 1 on trailing edges
    function automatic logic edge_samples(input logic cpha, input logic leading);
        return leading ^ cpha;
    endfunction

    // phase 0 must present the first bit before any edge
    function automatic logic presets_first_bit(input logic cpha);
        return !cpha;
    endfunction

endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // While stopped the counter is preloaded, so the first tick
    // comes a full half period after the clock is started.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run || cnt == '0) begin
            cnt <= half_div - 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              idle,
    input  logic              idle_cpol,
    input  logic              load,
    input  logic              load_cpha,
    input  logic [DATA_W-1:0] load_data,
    input  logic              cpha,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              last_edge,
    output logic [DATA_W-1:0] rx_word
);
    localparam int EDGES = 2 * DATA_W;
    localparam int IDX_W = $clog2(EDGES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(EDGES - 1);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              leading;
    logic              sample_now;

    always_comb begin
        leading    = edge_is_leading(idx[0]);
        sample_now = edge_samples(cpha, leading);
        last_edge  = tick && (idx == LAST_IDX);
    end

    // clock line
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk <= 1'b0;
        end else if (idle) begin
            sclk <= idle_cpol;
        end else if (tick) begin
            sclk <= ~sclk;
        end
    end

    // data path
    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
            mosi  <= 1'b0;
        end else if (load) begin
            idx <= '0;
            if (presets_first_bit(load_cpha)) begin
                mosi  <= load_data[DATA_W-1];
                tx_sh <= {load_data[DATA_W-2:0], 1'b0};
            end else begin
                tx_sh <= load_data;
            end
        end else if (tick) begin
            idx <= idx + 1'b1;
            if (sample_now) begin
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end else if (idx != LAST_IDX) begin
                mosi  <= tx_sh[DATA_W-1];
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign rx_word = rx_sh;

endmodule

// File: rtl/spim_seq.sv
module spim_seq
    import spim_pkg::*;
#(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_valid,
    input  logic             tx_keep_cs,
    input  logic             en_ok,
    input  logic             last_edge,
    input  logic [DLY_W-1:0] setup_ext,
    input  logic [DLY_W-1:0] hold_ext,
    output spim_state_e      state,
    output spim_ctl_t        ctl,
    output logic             tx_ready,
    output logic             done,
    output logic             cs_n
);
    logic [DLY_W-1:0] cnt;
    logic             keep_q;
    logic             hold_end;
    logic             accept;

    always_comb begin
        hold_end   = (state == ST_HOLD) && (cnt == '0);
        tx_ready   = (state == ST_IDLE) || (hold_end && keep_q);
        accept     = tx_valid && tx_ready;
        ctl.load   = accept;
        ctl.run    = (state == ST_SHIFT);
        ctl.idle   = (state == ST_IDLE);
        ctl.finish = hold_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            keep_q <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state  <= ST_SETUP;
                        cnt    <= setup_ext;
                        keep_q <= tx_keep_cs;
                        cs_n   <= 1'b0;
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_WAIT_EN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_WAIT_EN: begin
                    if (en_ok) begin
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (last_edge) begin
                        state <= ST_HOLD;
                        cnt   <= hold_ext;
                    end
                end
                ST_HOLD: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        done <= 1'b1;
                        if (accept) begin
                            state  <= ST_WAIT_EN;
                            keep_q <= tx_keep_cs;
                        end else begin
                            state <= ST_IDLE;
                            cs_n  <= 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cs_n  <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/spim_ready_hs.sv
module spim_ready_hs
    import spim_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int DLY_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [DLY_W-1:0]  setup_ext,
    input  logic [DLY_W-1:0]  hold_ext,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_keep_cs,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    input  logic              en_n
);
    spim_state_e        state;
    spim_ctl_t          ctl;
    logic               en_ok;
    logic               tick;
    logic               last_edge;
    logic               cpha_q;
    logic               load_cpha;
    logic [DIV_W-1:0]   half_q;
    logic [DATA_W-1:0]  rx_word;
    logic [SYNC_STAGES-1:0] en_sync;

    // ready line synchronizer, deasserted (high) out of reset
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) en_sync <= '1;
                else     en_sync <= en_n;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) en_sync <= '1;
                else     en_sync <= {en_sync[SYNC_STAGES-2:0], en_n};
            end
        end
    endgenerate

    assign en_ok = ~en_sync[SYNC_STAGES-1];

    // mode and divider are captured only on a word taken from idle;
    // words chained under a held select inherit them.
    always_ff @(posedge clk) begin
        if (rst) begin
            cpha_q <= 1'b0;
            half_q <= DIV_W'(1);
        end else if (ctl.load && ctl.idle) begin
            cpha_q <= cpha;
            half_q <= half_div;
        end
    end

    assign load_cpha = ctl.idle ? cpha : cpha_q;

    spim_seq #(.DLY_W(DLY_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tx_valid   (tx_valid),
        .tx_keep_cs (tx_keep_cs),
        .en_ok      (en_ok),
        .last_edge  (last_edge),
        .setup_ext  (setup_ext),
        .hold_ext   (hold_ext),
        .state      (state),
        .ctl        (ctl),
        .tx_ready   (tx_ready),
        .done       (rx_valid),
        .cs_n       (cs_n)
    );

    spim_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (ctl.run),
        .half_div (half_q),
        .tick     (tick)
    );

    spim_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .idle      (ctl.idle),
        .idle_cpol (cpol),
        .load      (ctl.load),
        .load_cpha (load_cpha),
        .load_data (tx_data),
        .cpha      (cpha_q),
        .tick      (tick),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .last_edge (last_edge),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
        end else if (ctl.finish) begin
            rx_data <= rx_word;
        end
    end

endmodule

// File: rtl/spim_ready_hs_chk.sv
module spim_ready_hs_chk
    import spim_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        cs_n,
    input logic        sclk,
    input logic        cpol,
    input logic        rx_valid,
    input spim_state_e state
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    assert_select_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && cs_n) |=> !cs_n);

    assert_ready_only_at_tail_R2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && tx_ready) |-> (state == ST_HOLD));

    assert_idle_clock_level_R1: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && cs_n && $past(cs_n) && $stable(cpol)) |-> (sclk == cpol));

    assert_no_edge_while_waiting_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_EN) |=> $stable(sclk));

    assert_rx_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_release_brings_data_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> rx_valid);

    assert_release_after_tail_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> ($past(state) == ST_HOLD));

endmodule

bind spim_ready_hs spim_ready_hs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .cpol     (cpol),
    .rx_valid (rx_valid),
    .state    (state)
);

// File: tb/spim_ready_hs_tb_top.sv
module spim_ready_hs_tb_top;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 8;
    localparam int DLY_W  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              cpol = 1'b0;
    logic              cpha = 1'b0;
    logic [DIV_W-1:0]  half_div = 8'd1;
    logic [DLY_W-1:0]  setup_ext = '0;
    logic [DLY_W-1:0]  hold_ext = '0;
    logic [DATA_W-1:0] tx_data = '0;
    logic              tx_valid = 1'b0;
    logic              tx_keep_cs = 1'b0;
    logic              tx_ready;
    logic [DATA_W-1:0] rx_data;
    logic              rx_valid;
    logic              sclk;
    logic              mosi;
    logic              miso = 1'b0;
    logic              cs_n;
    logic              en_n = 1'b0;

    spim_ready_hs dut_i (
        .clk(clk), .rst(rst), .cpol(cpol), .cpha(cpha), .half_div(half_div),
        .setup_ext(setup_ext), .hold_ext(hold_ext), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_keep_cs(tx_keep_cs), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .en_n(en_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check_eq(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected gaps in ns, from the requirements
    function automatic longint exp_setup_ns(input int h, input int su);
        return longint'(2 + su + h) * 10;
    endfunction
    function automatic longint exp_hold_ns(input int ho);
        return longint'(1 + ho) * 10;
    endfunction
    function automatic longint exp_ready_ns(input int h);
        return 5 + longint'(2 + h) * 10;
    endfunction

    // ---------------- slave model ----------------
    logic [7:0] sl_bytes [4];
    logic [7:0] mo_got [4];
    logic [7:0] rx_got [4];
    logic [7:0] sl_sh = '0;
    logic [7:0] mo = '0;
    int  sl_word = 0;
    int  words_done = 0;
    int  ecnt = 0;
    int  bad_half = 0;
    int  rx_n = 0;
    int  busy_ready = 0;
    int  cs_rises = 0;
    time t_cs_fall = 0, t_cs_rise = 0, t_first = 0, t_last = 0, t_prev = 0, t_rxv = 0;

    always @(negedge cs_n) begin
        t_cs_fall = $time;
        ecnt = 0;
        sl_sh = sl_bytes[sl_word % 4];
        if (!cpha) miso = sl_sh[7];
    end

    always @(posedge cs_n) begin
        t_cs_rise = $time;
        cs_rises++;
    end

    always @(sclk) begin
        if (cs_n === 1'b0) begin
            if (ecnt == 0) t_first = $time;
            else if ($time - t_prev != longint'(half_div) * 10) bad_half++;
            t_prev = $time;
            if ((sclk != cpol) ^ cpha) begin
                mo = {mo[6:0], mosi};
            end else if (cpha) begin
                miso = sl_sh[7];
                sl_sh = {sl_sh[6:0], 1'b0};
            end else begin
                sl_sh = {sl_sh[6:0], 1'b0};
                miso = sl_sh[7];
            end
            ecnt++;
            if (ecnt == 16) begin
                t_last = $time;
                mo_got[sl_word % 4] = mo;
                sl_word++;
                words_done++;
                ecnt = 0;
                sl_sh = sl_bytes[sl_word % 4];
                if (!cpha) miso = sl_sh[7];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                rx_got[rx_n % 4] = rx_data;
                t_rxv = $time;
                rx_n++;
            end
            if (!cs_n && tx_ready) busy_ready++;
        end
    end

    // ---------------- host driver ----------------
    task automatic put_word(input logic [7:0] d, input logic k);
        @(negedge clk);
        tx_data = d;
        tx_keep_cs = k;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic setup_cfg(input logic p, input logic ph, input int h, input int su, input int ho);
        @(negedge clk);
        cpol = p; cpha = ph;
        half_div = DIV_W'(h);
        setup_ext = DLY_W'(su);
        hold_ext = DLY_W'(ho);
        sl_word = 0; words_done = 0; rx_n = 0; bad_half = 0;
        busy_ready = 0; cs_rises = 0;
        repeat (2) @(negedge clk);
    endtask

    // one word, en_n low, full check of R2..R5, R7, R9, R10, R1
    task automatic one_word(input logic p, input logic ph, input int h, input int su,
                            input int ho, input logic [7:0] d, input logic [7:0] s,
                            input logic k);
        setup_cfg(p, ph, h, su, ho);
        sl_bytes[0] = s;
        put_word(d, k);
        wait (rx_n == 1);
        @(negedge clk);
        check_eq("R3 mosi byte", mo_got[0], d);
        check_eq("R3 edge count", words_done * 16 + ecnt, 16);
        check_eq("R7 rx byte", rx_got[0], s);
        check_eq("R7 strobe with release (ns)", t_rxv - t_cs_rise, 5);
        check_eq("R4 setup gap (ns)", t_first - t_cs_fall, exp_setup_ns(h, su));
        check_eq("R5 hold gap (ns)", t_cs_rise - t_last, exp_hold_ns(ho));
        check_eq("R10 bad half periods", bad_half, 0);
        check_eq("R2 busy ready cycles", busy_ready, k ? 1 : 0);
        check_eq("R9 select released", cs_n, 1);
        check_eq("R1 idle clock level", sclk, p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) sl_bytes[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 cs_n after reset", cs_n, 1);
        check_eq("R1 tx_ready after reset", tx_ready, 1);
        check_eq("R1 rx_valid after reset", rx_valid, 0);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1 idle clock follows cpol", sclk, 1);

        // directed corners: all four modes, extremes of delays
        one_word(1'b0, 1'b0, 1, 0, 0, 8'hA5, 8'h3C, 1'b0);
        one_word(1'b0, 1'b1, 2, 31, 0, 8'h81, 8'h7E, 1'b0);
        one_word(1'b1, 1'b0, 3, 0, 31, 8'h01, 8'h80, 1'b0);
        one_word(1'b1, 1'b1, 40, 5, 7, 8'hFF, 8'h00, 1'b0);
        // R9 keep flag with nothing waiting
        one_word(1'b0, 1'b1, 1, 2, 3, 8'h5A, 8'hC3, 1'b1);

        // R6: ready line holds off the first edge
        setup_cfg(1'b0, 1'b0, 2, 3, 2);
        sl_bytes[0] = 8'h96;
        en_n = 1'b1;
        put_word(8'h69, 1'b0);
        repeat (60) @(negedge clk);
        check_eq("R6 no edge while not ready", words_done * 16 + ecnt, 0);
        check_eq("R6 select held while waiting", cs_n, 0);
        @(negedge clk);
        en_n = 1'b0;
        begin
            time t_en;
            t_en = $time;
            wait (rx_n == 1);
            @(negedge clk);
            check_eq("R6 ready to first edge (ns)", t_first - t_en, exp_ready_ns(2));
        end
        check_eq("R6 data after wait", mo_got[0], 8'h69);
        check_eq("R7 rx after wait", rx_got[0], 8'h96);

        // R8 + R6: two words under held select, slave not ready between them
        setup_cfg(1'b1, 1'b1, 1, 0, 4);
        sl_bytes[0] = 8'h12;
        sl_bytes[1] = 8'hED;
        fork
            begin
                put_word(8'hC1, 1'b1);
                put_word(8'h3E, 1'b0);
            end
        join_none
        wait (words_done == 1);
        en_n = 1'b1;
        repeat (50) @(negedge clk);
        check_eq("R6 no edge after final edge while not ready", words_done * 16 + ecnt, 16);
        check_eq("R8 select kept between words", cs_n, 0);
        check_eq("R7 first strobe under held select", rx_n, 1);
        en_n = 1'b0;
        wait (rx_n == 2);
        @(negedge clk);
        check_eq("R8 select rises once", cs_rises, 1);
        check_eq("R8 first word out", mo_got[0], 8'hC1);
        check_eq("R8 second word out", mo_got[1], 8'h3E);
        check_eq("R8 first word in", rx_got[0], 8'h12);
        check_eq("R8 second word in", rx_got[1], 8'hED);
        check_eq("R2 ready only at chain point", busy_ready, 1);
        check_eq("R10 held run half periods", bad_half, 0);

        // random sweep
        for (int i = 0; i < 30; i++) begin
            one_word(1'($urandom), 1'($urandom), 1 + ($urandom % 4),
                     $urandom % 32, $urandom % 32, 8'($urandom), 8'($urandom),
                     1'($urandom));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule